// File: doc/BRIEF.md
# Control and Status Register Bank

This block is a small bank of 32-bit control and status words behind a single-cycle memory-mapped slave port. The address it receives is already a word index. Software writes and reads whole words: there are no byte lanes, no bursts and no wait states. A write takes effect at the clock edge that samples it. A read returns its data on the bus one clock after the request and holds it there until the next read.

Every bit of every word follows one of five access policies:

- a constant fixed at design time;
- a live view of a hardware status input;
- a read/write control bit;
- a sticky event bit that software clears by writing 1;
- a sticky event bit that clears when software reads it.

The hardware side supplies a status vector and two vectors of event pulses. The core logic receives the read/write words as control outputs.

Each word's per-bit policy is a constant record in the package. A word can therefore mix policies, as the mode word at index 6 does.

Top module: `csr_bank`

## Requirements
- R1: The bank holds seven 32-bit words at word indices 0 to 6: 0 identity, 1 control A, 2 control B, 3 live status, 4 write-one-to-clear events, 5 clear-on-read events, 6 mixed mode word.
- R2: `bus_waitrequest` is always 0. A write changes the addressed word at the clock edge that samples it, so the change is visible on the outputs one cycle after the request.
- R3: `bus_readdata` shows the addressed word's value from the request cycle, starting one clock after the request. It holds that value until the next read is sampled.
- R4: Word 0 always reads 0x5A170C03, and bits 15:8 of word 6 always read 0xA5. Writes do not change either.
- R5: Word 3 reads `hw_status` as it was in the request cycle. Bits 23:16 of word 6 read `hw_status[23:16]`. Writes change neither.
- R6: Words 1 and 2 and bits 7:0 of word 6 are read/write. They drive `ctrl_a`, `ctrl_b` and `ctrl_mode`, and every write replaces the whole field.
- R7: A 1 on `hw_evt_sticky[i]` sets bit i of word 4, and for i in 27:24 also bit i of word 6. The bit stays set until software writes 1 to it. Writing 0 leaves it unchanged.
- R8: If a write of 1 and a hardware set reach the same write-one-to-clear bit in the same cycle, the bit becomes 0.
- R9: A 1 on `hw_evt_cor[i]` sets bit i of word 5, and for i in 31:28 also bit i of word 6. A read returns the bit and then clears it.
- R10: If a hardware set reaches a clear-on-read bit in the same cycle as a read of its word, the read returns the old value and the bit stays 1 afterwards.
- R11: Reads of indices 7 and above return 0. Writes to them change no word and no control output.
- R12: Reset sets `ctrl_a` to 0x00000001, `ctrl_b` to 0x80000000 and `ctrl_mode` to 0x3C, clears all event bits, and sets `bus_readdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | ADDR_W (8) | Word index |
| bus_write | input | 1 | Write request |
| bus_writedata | input | 32 | Write data |
| bus_read | input | 1 | Read request |
| bus_readdata | output | 32 | Read data, valid one cycle after the request |
| bus_waitrequest | output | 1 | Tied to 0 |
| hw_status | input | 32 | Live status from the core |
| hw_evt_sticky | input | 32 | Event pulses for the write-one-to-clear bits |
| hw_evt_cor | input | 32 | Event pulses for the clear-on-read bits |
| ctrl_a | output | 32 | Control word A |
| ctrl_b | output | 32 | Control word B |
| ctrl_mode | output | 8 | Mode field from word 6 |

## Verification
The cases that are hardest to reach from the ports are the coincidences: a hardware event that lands in exactly the cycle in which software clears the same bit by a write (R8) or by a read (R10). The bench reaches them with a single bus-cycle task that drives the request and the event pulse together at the same falling edge and removes both at the next one. The rising edge in between therefore sees both at once. Follow-up reads then show whether the clear or the set survived. The mixed word is also read back after events on its shared lines, to confirm that each of its fields keeps its own policy.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_WORDS = 7;

  typedef logic [DATA_W-1:0] word_t;

  // Per-bit policy record for one word. init holds reset values for
  // read/write bits and the tied value for fixed bits.
  typedef struct packed {
    word_t rw;
    word_t w1c;
    word_t cor;
    word_t live;
    word_t fixed;
    word_t init;
  } word_policy_t;

  localparam int unsigned IDX_IDENT  = 0;
  localparam int unsigned IDX_CTRL_A = 1;
  localparam int unsigned IDX_CTRL_B = 2;
  localparam int unsigned IDX_STATUS = 3;
  localparam int unsigned IDX_STICKY = 4;
  localparam int unsigned IDX_EVCOR  = 5;
  localparam int unsigned IDX_MIXED  = 6;

  localparam word_t IDENT_CODE = 32'h5A17_0C03;
  localparam int unsigned MODE_W = 8;

  localparam word_policy_t POLICY [NUM_WORDS] = '{
    // identity: all fixed
    '{rw: '0, w1c: '0, cor: '0, live: '0, fixed: '1, init: IDENT_CODE},
    // control A
    '{rw: '1, w1c: '0, cor: '0, live: '0, fixed: '0, init: 32'h0000_0001},
    // control B
    '{rw: '1, w1c: '0, cor: '0, live: '0, fixed: '0, init: 32'h8000_0000},
    // live status
    '{rw: '0, w1c: '0, cor: '0, live: '1, fixed: '0, init: '0},
    // sticky events, write one to clear
    '{rw: '0, w1c: '1, cor: '0, live: '0, fixed: '0, init: '0},
    // sticky events, clear on read
    '{rw: '0, w1c: '0, cor: '1, live: '0, fixed: '0, init: '0},
    // mixed: [7:0] rw, [15:8] fixed, [23:16] live, [27:24] w1c, [31:28] cor
    '{rw:    32'h0000_00FF,
      w1c:   32'h0F00_0000,
      cor:   32'hF000_0000,
      live:  32'h00FF_0000,
      fixed: 32'h0000_FF00,
      init:  32'h0000_A53C}
  };

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 7
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_req,
  input  logic                 rd_req,
  output logic [NUM_WORDS-1:0] wr_hit,
  output logic [NUM_WORDS-1:0] rd_hit
);

  logic [NUM_WORDS-1:0] sel;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

  always_comb begin
    wr_hit = sel & {NUM_WORDS{wr_req}};
    rd_hit = sel & {NUM_WORDS{rd_req}};
  end

endmodule

// File: rtl/csr_word.sv
module csr_word
  import csr_bank_pkg::*;
#(
  parameter word_policy_t POL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hit,
  input  logic  rd_hit,
  input  word_t wdata,
  input  word_t w1c_set,
  input  word_t cor_set,
  input  word_t live_in,
  output word_t value
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (POL.rw[b]) begin : g_rw
      logic q, d, en;
      always_comb begin
        en = wr_hit;
        d  = wdata[b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= POL.init[b];
        else if (en) q <= d;
      end
      assign value[b] = q;
    end else if (POL.w1c[b]) begin : g_w1c
      logic q, d;
      // software clear overrides a same-cycle hardware set
      always_comb d = (q | w1c_set[b]) & ~(wr_hit & wdata[b]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
      end
      assign value[b] = q;
    end else if (POL.cor[b]) begin : g_cor
      logic q, d;
      // a set arriving with the read survives it
      always_comb d = (q & ~rd_hit) | cor_set[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
      end
      assign value[b] = q;
    end else if (POL.live[b]) begin : g_live
      assign value[b] = live_in[b];
    end else if (POL.fixed[b]) begin : g_fixed
      assign value[b] = POL.init[b];
    end else begin : g_none
      assign value[b] = 1'b0;
    end
  end

  logic unused_inputs;
  assign unused_inputs = ^{wdata, w1c_set, cor_set, live_in, wr_hit, rd_hit};

endmodule

// File: rtl/csr_read_port.sv
module csr_read_port
  import csr_bank_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req,
  input  logic [NUM_WORDS-1:0] rd_hit,
  input  word_t                words [NUM_WORDS],
  output word_t                rdata
);

  word_t mux_d, rdata_q, rdata_d;
  logic  en;

  always_comb begin
    mux_d = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      mux_d = mux_d | (words[i] & {DATA_W{rd_hit[i]}});
    end
    en      = rd_req;
    rdata_d = mux_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [31:0]       bus_writedata,
  input  logic              bus_read,
  output logic [31:0]       bus_readdata,
  output logic              bus_waitrequest,
  input  logic [31:0]       hw_status,
  input  logic [31:0]       hw_evt_sticky,
  input  logic [31:0]       hw_evt_cor,
  output logic [31:0]       ctrl_a,
  output logic [31:0]       ctrl_b,
  output logic [7:0]        ctrl_mode
);

  logic [NUM_WORDS-1:0] wr_hit, rd_hit;
  word_t                word_q [NUM_WORDS];

  csr_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS)
  ) u_decode (
    .addr  (bus_addr),
    .wr_req(bus_write),
    .rd_req(bus_read),
    .wr_hit(wr_hit),
    .rd_hit(rd_hit)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    csr_word #(
      .POL(POLICY[i])
    ) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit[i]),
      .rd_hit (rd_hit[i]),
      .wdata  (bus_writedata),
      .w1c_set(hw_evt_sticky),
      .cor_set(hw_evt_cor),
      .live_in(hw_status),
      .value  (word_q[i])
    );
  end

  csr_read_port #(
    .NUM_WORDS(NUM_WORDS)
  ) u_read (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_req(bus_read),
    .rd_hit(rd_hit),
    .words (word_q),
    .rdata (bus_readdata)
  );

  assign bus_waitrequest = 1'b0;
  assign ctrl_a          = word_q[IDX_CTRL_A];
  assign ctrl_b          = word_q[IDX_CTRL_B];
  assign ctrl_mode       = word_q[IDX_MIXED][MODE_W-1:0];

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
  import csr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [31:0]       bus_writedata,
  input logic              bus_read,
  input logic [31:0]       bus_readdata,
  input logic              bus_waitrequest,
  input logic [31:0]       hw_evt_cor,
  input logic [31:0]       ctrl_a,
  input logic [31:0]       sticky_q,
  input logic [31:0]       cor_q
);

  logic wr_a, wr_stk, rd_id, rd_cor, rd_unmapped;
  always_comb begin
    wr_a        = bus_write && (bus_addr == ADDR_W'(IDX_CTRL_A));
    wr_stk      = bus_write && (bus_addr == ADDR_W'(IDX_STICKY));
    rd_id       = bus_read  && (bus_addr == ADDR_W'(IDX_IDENT));
    rd_cor      = bus_read  && !bus_write && (bus_addr == ADDR_W'(IDX_EVCOR));
    rd_unmapped = bus_read  && (bus_addr >= ADDR_W'(NUM_WORDS));
  end

  assert_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_waitrequest == 1'b0);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_read |=> $stable(bus_readdata));

  assert_ident_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |=> bus_readdata == IDENT_CODE);

  assert_rw_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> ctrl_a == $past(bus_writedata));

  assert_rw_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_a |=> $stable(ctrl_a));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stk |=> (sticky_q & $past(bus_writedata)) == 32'h0);

  assert_cor_keep_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cor |=> cor_q == $past(hw_evt_cor));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> bus_readdata == 32'h0);

endmodule

bind csr_bank csr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_addr       (bus_addr),
  .bus_write      (bus_write),
  .bus_writedata  (bus_writedata),
  .bus_read       (bus_read),
  .bus_readdata   (bus_readdata),
  .bus_waitrequest(bus_waitrequest),
  .hw_evt_cor     (hw_evt_cor),
  .ctrl_a         (ctrl_a),
  .sticky_q       (word_q[csr_bank_pkg::IDX_STICKY]),
  .cor_q          (word_q[csr_bank_pkg::IDX_EVCOR])
);

// File: tb/csr_bank_tb_top.sv
module csr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_write, bus_read;
  logic [31:0] bus_writedata, bus_readdata;
  logic        bus_waitrequest;
  logic [31:0] hw_status, hw_evt_sticky, hw_evt_cor;
  logic [31:0] ctrl_a, ctrl_b;
  logic [7:0]  ctrl_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  csr_bank dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_write      (bus_write),
    .bus_writedata  (bus_writedata),
    .bus_read       (bus_read),
    .bus_readdata   (bus_readdata),
    .bus_waitrequest(bus_waitrequest),
    .hw_status      (hw_status),
    .hw_evt_sticky  (hw_evt_sticky),
    .hw_evt_cor     (hw_evt_cor),
    .ctrl_a         (ctrl_a),
    .ctrl_b         (ctrl_b),
    .ctrl_mode      (ctrl_mode)
  );

  localparam logic [31:0] IDENT = 32'h5A17_0C03;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bus cycle: inputs applied at a falling edge, removed at the next;
  // read data sampled after the rising edge in between.
  task automatic bus_cycle(input bit rd, input bit wr, input logic [7:0] a,
                           input logic [31:0] wd, input logic [31:0] stk,
                           input logic [31:0] cor, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_read = rd; bus_write = wr; bus_writedata = wd;
    hw_evt_sticky = stk; hw_evt_cor = cor;
    @(negedge clk);
    bus_read = 1'b0; bus_write = 1'b0; hw_evt_sticky = '0; hw_evt_cor = '0;
    d = bus_readdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_cycle(1'b1, 1'b0, a, '0, '0, '0, d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] d;
    bus_cycle(1'b0, 1'b1, a, wd, '0, '0, d);
  endtask

  task automatic pulse(input logic [31:0] stk, input logic [31:0] cor);
    logic [31:0] d;
    bus_cycle(1'b0, 1'b0, 8'h00, '0, stk, cor, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R12", "ctrl_a after reset", ctrl_a, 32'h0000_0001);
    check("R12", "ctrl_b after reset", ctrl_b, 32'h8000_0000);
    check("R12", "ctrl_mode after reset", {24'h0, ctrl_mode}, 32'h3C);
    check("R12", "readdata after reset", bus_readdata, 32'h0);
    check("R2", "waitrequest", {31'h0, bus_waitrequest}, 32'h0);
    rd(8'd0, d); check("R1", "word0", d, IDENT);
    rd(8'd1, d); check("R1", "word1", d, 32'h0000_0001);
    rd(8'd2, d); check("R1", "word2", d, 32'h8000_0000);
    rd(8'd4, d); check("R12", "word4 cleared", d, 32'h0);
    rd(8'd5, d); check("R12", "word5 cleared", d, 32'h0);
    rd(8'd6, d); check("R1", "word6", d, 32'h0000_A53C);
  endtask

  task automatic t_rw;
    logic [31:0] d;
    wr(8'd1, 32'hDEAD_BEEF);
    check("R2", "ctrl_a right after write", ctrl_a, 32'hDEAD_BEEF);
    wr(8'd2, 32'h0BAD_F00D);
    check("R6", "ctrl_b", ctrl_b, 32'h0BAD_F00D);
    check("R6", "ctrl_a kept", ctrl_a, 32'hDEAD_BEEF);
    rd(8'd1, d); check("R6", "word1 readback", d, 32'hDEAD_BEEF);
    wr(8'd6, 32'hFFFF_FFFF);
    check("R6", "ctrl_mode", {24'h0, ctrl_mode}, 32'hFF);
    rd(8'd6, d); check("R6", "word6 after all-ones", d, 32'h0000_A5FF);
  endtask

  task automatic t_ro;
    logic [31:0] d;
    wr(8'd0, 32'h0);
    rd(8'd0, d); check("R4", "identity after write", d, IDENT);
    hw_status = 32'h1234_5678;
    wr(8'd3, 32'hFFFF_FFFF);
    rd(8'd3, d); check("R5", "status word", d, 32'h1234_5678);
    rd(8'd6, d); check("R5", "word6 live field", d, 32'h0034_A5FF);
    @(negedge clk);
    hw_status = 32'hCAFE_0001; bus_addr = 8'd3; bus_read = 1'b1;
    @(negedge clk);
    bus_read = 1'b0; hw_status = 32'h0;
    check("R3", "status sampled in request cycle", bus_readdata, 32'hCAFE_0001);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    pulse(32'h0000_00F0, '0);
    rd(8'd4, d); check("R7", "sticky set", d, 32'h0000_00F0);
    rd(8'd4, d); check("R7", "sticky not cleared by read", d, 32'h0000_00F0);
    wr(8'd4, 32'h0000_0030);
    rd(8'd4, d); check("R7", "write one clears", d, 32'h0000_00C0);
    wr(8'd4, 32'h0);
    rd(8'd4, d); check("R7", "write zero keeps", d, 32'h0000_00C0);
    bus_cycle(1'b0, 1'b1, 8'd4, 32'h0000_0180, 32'h0000_0300, '0, d);
    rd(8'd4, d); check("R8", "clear beats same-cycle set", d, 32'h0000_0240);
  endtask

  task automatic t_cor;
    logic [31:0] d;
    pulse('0, 32'h0000_000F);
    rd(8'd5, d); check("R9", "cor value", d, 32'h0000_000F);
    rd(8'd5, d); check("R9", "cor cleared by read", d, 32'h0);
    pulse('0, 32'h0000_0003);
    bus_cycle(1'b1, 1'b0, 8'd5, '0, '0, 32'h0000_0010, d);
    check("R10", "read returns old value", d, 32'h0000_0003);
    rd(8'd5, d); check("R10", "set during read kept", d, 32'h0000_0010);
    rd(8'd5, d); check("R9", "cleared again", d, 32'h0);
  endtask

  task automatic t_mixed;
    logic [31:0] d;
    wr(8'd4, 32'hFFFF_FFFF);
    pulse(32'h0500_0000, 32'hA000_0000);
    rd(8'd6, d); check("R9", "word6 both event fields", d, 32'hA500_A5FF);
    rd(8'd6, d); check("R9", "word6 cor field cleared", d, 32'h0500_A5FF);
    wr(8'd6, 32'h0100_0011);
    rd(8'd6, d); check("R7", "word6 after mixed write", d, 32'h0400_A511);
    check("R6", "ctrl_mode from word6", {24'h0, ctrl_mode}, 32'h11);
    rd(8'd4, d); check("R7", "word4 shares event line", d, 32'h0500_0000);
    rd(8'd5, d); check("R9", "word5 shares event line", d, 32'hA000_0000);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'd7, d);  check("R11", "index 7 reads zero", d, 32'h0);
    rd(8'hFF, d); check("R11", "index 255 reads zero", d, 32'h0);
    wr(8'd7, 32'hFFFF_FFFF);
    wr(8'h80, 32'h0);
    check("R11", "ctrl_a untouched", ctrl_a, 32'hDEAD_BEEF);
    check("R11", "ctrl_b untouched", ctrl_b, 32'h0BAD_F00D);
    check("R11", "ctrl_mode untouched", {24'h0, ctrl_mode}, 32'h11);
    rd(8'd4, d); check("R11", "word4 untouched", d, 32'h0500_0000);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    rd(8'd0, d);
    hw_status = 32'h7777_7777;
    pulse(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    check("R3", "readdata held while idle", bus_readdata, IDENT);
    check("R2", "waitrequest idle", {31'h0, bus_waitrequest}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_write = 1'b0; bus_read = 1'b0;
    bus_writedata = '0; hw_status = '0; hw_evt_sticky = '0; hw_evt_cor = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_ro();
    t_w1c();
    t_cor();
    t_mixed();
    t_unmapped();
    t_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule